// File: doc/BRIEF.md
# Banked Gather-Read Scratchpad

This block is an on-chip scratchpad split into 32 banks, each returning one 32-bit word per cycle. Each request comes from a group of 32 lanes. Every lane gives a word address and an enable bit. The bank of a word is its address modulo 32, and its row is the address divided by 32. The block serves the request in as few bank passes as the conflict rules allow. It collects the data of every lane in a register and then raises a one-cycle done pulse together with the number of passes used.

In each pass, every bank with lanes still waiting takes the word of its lowest-numbered waiting lane. Every waiting lane that wants that same word gets it by broadcast in that pass. Lanes that want other words in the same bank wait for later passes. A mode bit is sampled with each request. It selects plain interleaving or a paired mode. In paired mode a bank returns the two rows of one 64-word-aligned segment together, so words i and i+32 of that segment count as a single fetch.

A single-lane write port loads the contents. While a read is in progress the block drops both its request-ready and its write-ready. A write or a request offered in that time is not performed. The source holds it until the block is ready again.

Top module: `banked_scratchpad`

## Requirements
- R1: After reset, req_ready and wr_ready are 1, rsp_done is 0, rsp_passes is 0 and every lane of rsp_data is 0.
- R2: The bank of a word is bits [4:0] of its address and its row is bits [9:5]. A request whose active lanes all fall in different banks finishes in 1 pass.
- R3: Active lanes that name the same word are served together in one pass, whether all lanes or only some lanes share it. Each of them receives that word.
- R4: In plain mode (wide_mode=0) the pass count equals the largest number of distinct words that any single bank must supply. For example, address stride 16 over 32 lanes takes 16 passes and stride 32 takes 32 passes.
- R5: In paired mode (wide_mode=1), two words of one bank whose rows differ only in bit 0 (the same 64-word-aligned segment) count as one fetch. Stride 32 over 32 lanes then takes 16 passes. Words 32 and 64 lie in different segments and still take 2 passes.
- R6: Inactive lanes return 0 and do not add to the pass count. A request with no active lane completes with rsp_passes = 0.
- R7: rsp_done is high exactly N cycles after the clock edge that accepts the request, where N = rsp_passes. req_ready is low in between and high again in the done cycle. rsp_data and rsp_passes are valid with rsp_done and stay unchanged until the next request is accepted.
- R8: A write is performed at the clock edge where wr_en is high and wr_ready is high. A write offered while wr_ready is low leaves the memory unchanged.
- R9: A request offered while req_ready is low is ignored. The running request completes with its own addresses and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects paired-row banking; sampled with the request |
| req_valid | input | 1 | Gather request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_active | input | 32 | Per-lane enable, bit n for lane n |
| req_addr | input | 320 | Per-lane word address, lane n at bits [10n+9:10n] |
| rsp_done | output | 1 | One-cycle pulse: all lane data collected |
| rsp_passes | output | 6 | Number of bank passes the last request took |
| rsp_data | output | 1024 | Per-lane read word, lane n at bits [32n+31:32n] |
| wr_en | input | 1 | Write offered |
| wr_ready | output | 1 | Write will be performed at this edge |
| wr_addr | input | 10 | Word address of the write |
| wr_data | input | 32 | Word to write |

## Verification
A request that needs N passes is accepted at one edge, and the done pulse follows exactly N edges later. The result data and count are held from then on. The bench drives inputs on the falling edge and keeps track of the edges after acceptance. It samples on each falling edge and checks that the number of cycles before done, the reported pass count and the pass count worked out from the addresses all agree. A write lands at the edge it is accepted, so the bench reads it back only with a later request. The effect of a stalled write or request is checked at the ports during the busy window. After that, the bench checks the finished data of the running read and reads back the targeted word.

// File: rtl/spad_pkg.sv
package spad_pkg;
  parameter int LANES  = 32;
  parameter int BANKS  = 32;
  parameter int ROWS   = 32;
  parameter int DATA_W = 32;
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int ADDR_W = BANK_W + ROW_W;
  localparam int CNT_W  = $clog2(LANES + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [BANK_W-1:0] bank_t;

  // bank = word address modulo bank count
  function automatic bank_t bank_of(addr_t a);
    return a[BANK_W-1:0];
  endfunction

  function automatic row_t row_of(addr_t a);
    return a[ADDR_W-1:BANK_W];
  endfunction

  // fetch key inside a bank: the row, or the even row of the pair in wide mode
  function automatic row_t key_of(addr_t a, logic wide);
    row_t r;
    r = row_of(a);
    if (wide) r[0] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int ROWS   = 32,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  row_a,
  input  logic [ROW_W-1:0]  row_b,
  output logic [DATA_W-1:0] data_a,
  output logic [DATA_W-1:0] data_b
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= wdata;
  end

  // port b only matters in wide mode, where it supplies the odd row of a pair
  assign data_a = mem[row_a];
  assign data_b = mem[row_b];
endmodule

// File: rtl/sp_arbiter.sv
module sp_arbiter
  import spad_pkg::*;
(
  input  logic [LANES-1:0] pending,
  input  addr_t            lane_addr [LANES],
  input  logic             wide,
  output logic [BANKS-1:0] lead_valid,
  output row_t             lead_key [BANKS],
  output logic [LANES-1:0] serve
);
  // per bank: key of the lowest-numbered waiting lane (scan downward, last hit wins)
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      lead_valid[b] = 1'b0;
      lead_key[b]   = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && bank_of(lane_addr[l]) == bank_t'(b)) begin
          lead_valid[b] = 1'b1;
          lead_key[b]   = key_of(lane_addr[l], wide);
        end
      end
    end
  end

  // a waiting lane is served when it wants the fetch its bank chose
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      serve[l] = pending[l] &&
                 (key_of(lane_addr[l], wide) == lead_key[bank_of(lane_addr[l])]);
    end
  end
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
  import spad_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wide_mode,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [LANES-1:0]         req_active,
  input  logic [LANES*ADDR_W-1:0]  req_addr,
  output logic                     rsp_done,
  output logic [CNT_W-1:0]         rsp_passes,
  output logic [LANES*DATA_W-1:0]  rsp_data,
  input  logic                     wr_en,
  output logic                     wr_ready,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data
);
  logic                    busy;
  logic                    wide_q;
  logic                    done_q;
  logic [CNT_W-1:0]        pass_q;
  logic [LANES-1:0]        pending;
  logic [LANES*ADDR_W-1:0] addr_q;
  word_t                   rd_q [LANES];

  addr_t            lane_addr [LANES];
  word_t            lane_word [LANES];
  word_t            bank_a    [BANKS];
  word_t            bank_b    [BANKS];
  row_t             lead_key  [BANKS];
  logic [BANKS-1:0] lead_valid;
  logic [BANKS-1:0] bank_we;
  logic [LANES-1:0] serve;

  // named events
  logic             accept;
  logic             wr_fire;
  logic             pass_fire;
  logic [LANES-1:0] pending_left;

  assign accept       = req_valid && !busy;
  assign wr_fire      = wr_en && !busy;
  assign pass_fire    = busy;
  assign pending_left = pending & ~serve;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_addr[l]                  = addr_q[l*ADDR_W +: ADDR_W];
    assign rsp_data[l*DATA_W +: DATA_W]  = rd_q[l];
  end

  sp_arbiter u_arb (
    .pending    (pending),
    .lane_addr  (lane_addr),
    .wide       (wide_q),
    .lead_valid (lead_valid),
    .lead_key   (lead_key),
    .serve      (serve)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_we[b] = wr_fire && (bank_of(wr_addr) == bank_t'(b));
    sp_bank #(.ROWS(ROWS), .DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .we     (bank_we[b]),
      .wrow   (row_of(wr_addr)),
      .wdata  (wr_data),
      .row_a  (lead_key[b]),
      .row_b  (lead_key[b] | row_t'(1)),
      .data_a (bank_a[b]),
      .data_b (bank_b[b])
    );
  end

  // each lane picks the even or odd row output of its bank
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      row_t r;
      r = row_of(lane_addr[l]);
      lane_word[l] = (wide_q && r[0]) ? bank_b[bank_of(lane_addr[l])]
                                      : bank_a[bank_of(lane_addr[l])];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= '0;
      pending <= '0;
      addr_q  <= '0;
      for (int l = 0; l < LANES; l++) rd_q[l] <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q  <= req_addr;
        wide_q  <= wide_mode;
        pending <= req_active;
        pass_q  <= '0;
        for (int l = 0; l < LANES; l++) rd_q[l] <= '0;
        busy    <= |req_active;
        done_q  <= ~|req_active;
      end else if (pass_fire) begin
        pending <= pending_left;
        pass_q  <= pass_q + CNT_W'(1);
        for (int l = 0; l < LANES; l++)
          if (serve[l]) rd_q[l] <= lane_word[l];
        if (pending_left == '0) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign req_ready  = !busy;
  assign wr_ready   = !busy;
  assign rsp_done   = done_q;
  assign rsp_passes = pass_q;

  AST_PASS_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
    pass_fire |-> serve != '0);  // R4
  AST_SERVE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    pass_fire |-> (serve & ~pending) == '0);  // R6
  AST_LEAD_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    pass_fire |-> lead_valid != '0);  // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (req_ready && pending == '0));  // R7
  AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_passes <= CNT_W'(LANES));  // R4
  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> bank_we == '0);  // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));  // R9
endmodule

// File: tb/tb_banked_scratchpad.sv
module tb_banked_scratchpad;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wide_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_active = '0;
  logic [319:0]  req_addr = '0;
  logic          rsp_done;
  logic [5:0]    rsp_passes;
  logic [1023:0] rsp_data;
  logic          wr_en = 1'b0;
  logic          wr_ready;
  logic [9:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] model [1024];
  int    la [32];
  logic  act [32];

  always #5 clk = ~clk;

  banked_scratchpad dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr),
    .rsp_done(rsp_done), .rsp_passes(rsp_passes), .rsp_data(rsp_data),
    .wr_en(wr_en), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string req, logic ok, longint act_v, longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic int exp_passes(logic wide);
    int best = 0;
    for (int b = 0; b < 32; b++) begin
      int keys [32];
      int n = 0;
      for (int l = 0; l < 32; l++) begin
        if (act[l] && (la[l] % 32) == b) begin
          int k = wide ? la[l] / 64 : la[l] / 32;
          bit seen = 0;
          for (int i = 0; i < n; i++) if (keys[i] == k) seen = 1;
          if (!seen) begin keys[n] = k; n++; end
        end
      end
      if (n > best) best = n;
    end
    return best;
  endfunction

  task automatic drive_req(logic wide);
    wide_mode = wide;
    for (int l = 0; l < 32; l++) begin
      req_active[l] = act[l];
      req_addr[l*10 +: 10] = 10'(la[l]);
    end
    req_valid = 1'b1;
  endtask

  // offers the request at a falling edge, optionally intrudes while busy, checks results
  task automatic do_read(string req, logic wide, logic intrude);
    int exp_n;
    int k = 0;
    logic [31:0] keep;
    exp_n = exp_passes(wide);
    drive_req(wide);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude && !rsp_done) begin
      // R9/R8: offer another request and a write while busy
      req_active = '1;
      req_addr   = '0;
      req_valid  = 1'b1;
      wr_en = 1'b1; wr_addr = 10'd100; keep = model[100]; wr_data = ~keep;
      check("R9 req_ready low while busy", req_ready == 1'b0, req_ready, 0);
      check("R8 wr_ready low while busy", wr_ready == 1'b0, wr_ready, 0);
      @(negedge clk);
      k++;
      @(negedge clk);
      k++;
      req_valid = 1'b0;
      wr_en = 1'b0;
    end
    while (!rsp_done && k < 100) begin
      @(negedge clk);
      k++;
    end
    check({req, " R7 done latency"}, k == exp_n, k, exp_n);
    check({req, " pass count"}, rsp_passes == 6'(exp_n), rsp_passes, exp_n);
    check({req, " R7 ready at done"}, req_ready == 1'b1, req_ready, 1);
    begin
      int bad = -1;
      logic [31:0] e;
      logic [31:0] a;
      for (int l = 31; l >= 0; l--) begin
        e = act[l] ? model[la[l]] : 32'h0;
        a = rsp_data[l*32 +: 32];
        if (a != e) bad = l;
      end
      if (bad >= 0) begin
        e = act[bad] ? model[la[bad]] : 32'h0;
        check({req, " lane data"}, 1'b0, rsp_data[bad*32 +: 32], e);
      end else check({req, " lane data"}, 1'b1, 0, 0);
    end
    @(negedge clk);
    check({req, " R7 done is one pulse"}, rsp_done == 1'b0, rsp_done, 0);
    check({req, " R7 result held"}, rsp_passes == 6'(exp_n), rsp_passes, exp_n);
  endtask

  task automatic set_stride(int base, int stride);
    for (int l = 0; l < 32; l++) begin
      la[l]  = (base + l * stride) % 1024;
      act[l] = 1'b1;
    end
  endtask

  task automatic t_reset();
    check("R1 req_ready", req_ready == 1'b1, req_ready, 1);
    check("R1 wr_ready", wr_ready == 1'b1, wr_ready, 1);
    check("R1 done", rsp_done == 1'b0, rsp_done, 0);
    check("R1 passes", rsp_passes == 6'd0, rsp_passes, 0);
    check("R1 data", rsp_data == '0, rsp_data[31:0], 0);
  endtask

  task automatic t_load();
    for (int a = 0; a < 1024; a++) begin
      wr_en = 1'b1;
      wr_addr = 10'(a);
      wr_data = 32'hC000_0000 ^ (32'(a) * 32'h0001_0107);
      model[a] = wr_data;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic t_distinct_banks();
    set_stride(40, 1);
    do_read("R2 consecutive words", 1'b0, 1'b0);
    set_stride(5, 33);
    do_read("R2 stride 33", 1'b0, 1'b0);
  endtask

  task automatic t_broadcast();
    for (int l = 0; l < 32; l++) begin la[l] = 77; act[l] = 1'b1; end
    do_read("R3 full broadcast", 1'b0, 1'b0);
    for (int l = 0; l < 32; l++) begin la[l] = (l % 2) ? 37 : 69; act[l] = 1'b1; end
    do_read("R3 partial broadcast", 1'b0, 1'b0);
  endtask

  task automatic t_conflicts();
    set_stride(0, 16);
    do_read("R4 stride 16 plain", 1'b0, 1'b0);
    set_stride(3, 32);
    do_read("R4 stride 32 plain", 1'b0, 1'b0);
  endtask

  task automatic t_wide();
    set_stride(3, 32);
    do_read("R5 stride 32 wide", 1'b1, 1'b0);
    set_stride(0, 64);
    do_read("R5 stride 64 wide", 1'b1, 1'b0);
    for (int l = 0; l < 32; l++) begin la[l] = (l % 2) ? 64 : 32; act[l] = 1'b1; end
    do_read("R5 pair across segments", 1'b1, 1'b0);
    for (int l = 0; l < 32; l++) begin la[l] = (l % 2) ? 96 : 64; act[l] = 1'b1; end
    do_read("R5 aligned pair", 1'b1, 1'b0);
  endtask

  task automatic t_inactive();
    set_stride(0, 16);
    for (int l = 8; l < 32; l++) act[l] = 1'b0;
    do_read("R6 eight active lanes", 1'b0, 1'b0);
    for (int l = 0; l < 32; l++) act[l] = 1'b0;
    do_read("R6 no active lane", 1'b0, 1'b0);
  endtask

  task automatic t_busy_stall();
    logic [31:0] old;
    old = model[100];
    set_stride(0, 16);
    do_read("R9 stride 16 with intruder", 1'b0, 1'b1);
    for (int l = 0; l < 32; l++) begin la[l] = 100; act[l] = (l == 4); end
    do_read("R8 stalled write left memory", 1'b0, 1'b0);
    check("R8 stalled write word", rsp_data[4*32 +: 32] == old, rsp_data[4*32 +: 32], old);
  endtask

  task automatic t_write();
    check("R8 wr_ready idle", wr_ready == 1'b1, wr_ready, 1);
    wr_en = 1'b1; wr_addr = 10'd100; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_en = 1'b0;
    model[100] = 32'hDEAD_BEEF;
    for (int l = 0; l < 32; l++) begin la[l] = 100; act[l] = (l == 3); end
    do_read("R8 write readback", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load();
    t_distinct_banks();
    t_broadcast();
    t_conflicts();
    t_wide();
    t_inactive();
    t_busy_stall();
    t_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule